// File: doc/BRIEF.md
# Periodic Real-Time Tick Generator

The block divides the bus clock into a steady real-time tick. A small rate field picks one of four periods, each a power-of-two multiple of a base period. Every completed period raises a sticky real-time flag, which software clears by writing a one to it. A separate enable bit gates that flag onto a level interrupt request line.

Three write-only register selects are decoded: a control select, a flag select and a mask select. Their current contents are brought straight out as ports. When the rate field is reprogrammed, the free-running schedule is not restarted. The next tick is placed one new period after the previous tick. If that moment has already passed, the tick comes on the very next cycle. A rate write never raises the flag by itself.

Top module: `rt_tick_gen`

## Requirements
- R1: With rate field value n, ticks are spaced 2^(BASE_LOG2+n) bus cycles apart (8192, 16384, 32768 or 65536 cycles at the default BASE_LOG2 = 13). After reset with no writes, the first tick happens on the 2^BASE_LOG2-th rising edge after reset is released. tick_o is high during the cycle before that edge.
- R2: Each tick sets flag_o, which is visible from the edge on which the tick completes.
- R3: A write with wr_sel = 2'b01 clears flag_o when wr_data[FLAG_BIT] (default bit 6) is 1. When that bit is 0, the write leaves flag_o unchanged.
- R4: If a clearing flag write and a tick fall on the same edge, the flag ends up set.
- R5: A write to the rate field never sets flag_o.
- R6: After a rate write, the next tick completes exactly one new period after the edge of the previous tick. Later ticks then follow at the new period.
- R7: If, at the edge where the rate write lands, the new period has already elapsed since the previous tick, the tick completes on the following edge.
- R8: Reset (rst_n low, asynchronous) clears the rate field to 0, flag_o to 0 and enable_o to 0. It also restarts the tick timing from zero.
- R9: irq_o is high exactly when both flag_o and enable_o are high.
- R10: A write with wr_sel = 2'b00 loads the rate field from wr_data[RATE_LSB +: RATE_W] (default bits 1:0). A write with wr_sel = 2'b10 loads enable_o from wr_data[IEN_BIT] (default bit 6). A write with wr_sel = 2'b11 changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select: 00 control, 01 flag, 10 mask, 11 none |
| wr_data | input | DATA_W | Write data |
| rate_o | output | RATE_W | Current rate field |
| enable_o | output | 1 | Real-time interrupt enable |
| flag_o | output | 1 | Real-time flag |
| irq_o | output | 1 | Interrupt request |
| tick_o | output | 1 | High in the cycle whose closing edge completes a period |

## Verification
The main instance is built with BASE_LOG2 = 4, which gives periods of 16, 32, 64 and 128 cycles. At that size the bench can reach every rate, a rate shortened below the time already elapsed, and a flag clear that collides with a tick, all edge-exact. A second instance keeps the default BASE_LOG2 = 13 and sits idle after reset. It confirms that the first tick lands on edge 8192 and not one edge earlier.

// File: rtl/rt_tick_pkg.sv
package rt_tick_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'b00,
      SEL_FLAG = 2'b01,
      SEL_MASK = 2'b10,
      SEL_NONE = 2'b11
   } rt_sel_e;

   // counter width able to hold the longest period of the table
   function automatic int unsigned span_bits(int unsigned base_log2, int unsigned rate_w);
      return base_log2 + (32'd1 << rate_w);
   endfunction

endpackage

// File: rtl/rt_tick_regs.sv
module rt_tick_regs
   import rt_tick_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RATE_W   = 2,
   parameter int unsigned RATE_LSB = 0,
   parameter int unsigned FLAG_BIT = 6,
   parameter int unsigned IEN_BIT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [RATE_W-1:0] rate_q,
   output logic              ien_q,
   output logic              flag_clr
);

   logic ctrl_wr, mask_wr, unused_data;

   assign ctrl_wr     = wr_en && (rt_sel_e'(wr_sel) == SEL_CTRL);
   assign mask_wr     = wr_en && (rt_sel_e'(wr_sel) == SEL_MASK);
   assign flag_clr    = wr_en && (rt_sel_e'(wr_sel) == SEL_FLAG) && wr_data[FLAG_BIT];
   assign unused_data = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
         ien_q  <= 1'b0;
      end else begin
         if (ctrl_wr) rate_q <= wr_data[RATE_LSB +: RATE_W];
         if (mask_wr) ien_q  <= wr_data[IEN_BIT];
      end
   end

   // R10: the rate field moves only through a control write
   a_r10_rate_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q != $past(rate_q)) |-> $past(ctrl_wr));

   // R10: the enable moves only through a mask write
   a_r10_ien_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q != $past(ien_q)) |-> $past(mask_wr));

endmodule

// File: rtl/rt_tick_timebase.sv
module rt_tick_timebase #(
   parameter int unsigned BASE_LOG2 = 13,
   parameter int unsigned RATE_W    = 2,
   parameter int unsigned CNT_W     = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);

   localparam int unsigned NRATE = 1 << RATE_W;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt [NRATE];

   // one terminal count per rate value: period - 1
   for (genvar g = 0; g < NRATE; g++) begin : g_rate
      localparam longint unsigned LEN = 64'd1 << (BASE_LOG2 + g);
      assign last_cnt[g] = CNT_W'(LEN - 64'd1);
   end

   // compare with >= so a shortened period that already elapsed fires at once
   assign tick = (cnt >= last_cnt[rate]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

   // R6: timing restarts from the tick edge, never two ticks back to back
   a_r6_restart_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> ((cnt == '0) && !tick));

endmodule

// File: rtl/rt_tick_flag.sv
module rt_tick_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   input  logic ien,
   output logic flag_q,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (tick) flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
   end

   assign irq = flag_q & ien;

   a_r2_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> flag_q);

   a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !tick) |=> !flag_q);

   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && tick) |=> flag_q);

   a_r5_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick));

endmodule

// File: rtl/rt_tick_gen.sv
module rt_tick_gen
   import rt_tick_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 13,
   parameter int unsigned RATE_W    = 2,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RATE_LSB  = 0,
   parameter int unsigned FLAG_BIT  = 6,
   parameter int unsigned IEN_BIT   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [RATE_W-1:0] rate_o,
   output logic              enable_o,
   output logic              flag_o,
   output logic              irq_o,
   output logic              tick_o
);

   localparam int unsigned CNT_W = span_bits(BASE_LOG2, RATE_W);

   if (BASE_LOG2 < 1 || BASE_LOG2 > 40) begin : g_bad_base
      $error("rt_tick_gen: BASE_LOG2 out of range");
   end
   if (RATE_W < 1 || RATE_W > 3) begin : g_bad_rate
      $error("rt_tick_gen: RATE_W out of range");
   end
   if (RATE_LSB + RATE_W > DATA_W || FLAG_BIT >= DATA_W || IEN_BIT >= DATA_W) begin : g_bad_field
      $error("rt_tick_gen: field outside data word");
   end

   logic flag_clr;

   rt_tick_regs #(
      .DATA_W(DATA_W), .RATE_W(RATE_W), .RATE_LSB(RATE_LSB),
      .FLAG_BIT(FLAG_BIT), .IEN_BIT(IEN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rate_q(rate_o), .ien_q(enable_o), .flag_clr(flag_clr)
   );

   rt_tick_timebase #(
      .BASE_LOG2(BASE_LOG2), .RATE_W(RATE_W), .CNT_W(CNT_W)
   ) u_time (
      .clk(clk), .rst_n(rst_n), .rate(rate_o), .tick(tick_o)
   );

   rt_tick_flag u_flag (
      .clk(clk), .rst_n(rst_n), .tick(tick_o), .clr(flag_clr),
      .ien(enable_o), .flag_q(flag_o), .irq(irq_o)
   );

   // R9: a request never stands without its enable
   a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (enable_o && flag_o));

endmodule

// File: tb/rt_tick_gen_test.sv
`timescale 1ns/1ps
module rt_tick_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'b00;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] rate_o, rate_d;
   logic       enable_o, flag_o, irq_o, tick_o;
   logic       enable_d, flag_d, irq_d, tick_d;

   int n_chk = 0;
   int n_bad = 0;
   int edges = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;

   rt_tick_gen #(.BASE_LOG2(4)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rate_o(rate_o), .enable_o(enable_o), .flag_o(flag_o), .irq_o(irq_o), .tick_o(tick_o)
   );

   rt_tick_gen uut_dflt (
      .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wr_sel(2'b11), .wr_data(8'h00),
      .rate_o(rate_d), .enable_o(enable_d), .flag_o(flag_d), .irq_o(irq_d), .tick_o(tick_d)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s at edge %0d: got %0h expected %0h", req, edges, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // wait until the negedge after edge n
   task automatic goto(input int n);
      while (edges < n) @(negedge clk);
   endtask

   // issued at a negedge after edge k, lands on edge k+1
   task automatic bus_wr(input logic [1:0] sel, input logic [7:0] data);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic t_reset_and_first_tick();
      do_reset();
      check("R8 rate", rate_o, 0);
      check("R8 flag", flag_o, 0);
      check("R8 enable", enable_o, 0);
      check("R8 irq", irq_o, 0);
      goto(15);
      check("R1 no early flag", flag_o, 0);
      check("R1 tick_o before edge 16", tick_o, 1);
      goto(16);
      check("R2 flag after first tick", flag_o, 1);
      check("R9 irq masked", irq_o, 0);
      bus_wr(2'b10, 8'h40);
      check("R10 enable set", enable_o, 1);
      check("R9 irq on", irq_o, 1);
      bus_wr(2'b11, 8'hFF);
      check("R10 none select rate", rate_o, 0);
      check("R10 none select flag", flag_o, 1);
      check("R10 none select enable", enable_o, 1);
      bus_wr(2'b01, 8'hBF);
      check("R3 zero bit keeps flag", flag_o, 1);
      bus_wr(2'b01, 8'h40);
      check("R3 w1c clears", flag_o, 0);
      check("R9 irq off", irq_o, 0);
      bus_wr(2'b10, 8'hBF);
      check("R10 enable cleared", enable_o, 0);
   endtask

   task automatic t_collision();
      do_reset();
      goto(16);
      bus_wr(2'b01, 8'h40);
      check("R3 clear before collision", flag_o, 0);
      goto(31);
      bus_wr(2'b01, 8'h40);
      check("R4 set wins", flag_o, 1);
   endtask

   task automatic t_rate_longer();
      do_reset();
      goto(16);
      bus_wr(2'b01, 8'h40);
      goto(19);
      bus_wr(2'b00, 8'h02);
      check("R10 rate loaded", rate_o, 2);
      check("R5 no flag from rate write", flag_o, 0);
      goto(79);
      check("R6 no early tick", flag_o, 0);
      goto(80);
      check("R6 tick one new period after last", flag_o, 1);
      bus_wr(2'b01, 8'h40);
      goto(143);
      check("R6 following period", tick_o, 1);
   endtask

   task automatic t_rate_longest();
      do_reset();
      bus_wr(2'b00, 8'h03);
      goto(127);
      check("R1 128 cycle period early", flag_o, 0);
      goto(128);
      check("R1 128 cycle period", flag_o, 1);
   endtask

   task automatic t_rate_elapsed();
      do_reset();
      goto(16);
      bus_wr(2'b00, 8'h03);
      bus_wr(2'b01, 8'h40);
      goto(100);
      bus_wr(2'b00, 8'h01);
      check("R5 shorten no flag", flag_o, 0);
      check("R7 tick_o next cycle", tick_o, 1);
      goto(102);
      check("R7 late tick fires next edge", flag_o, 1);
      goto(133);
      check("R6 period after late tick", tick_o, 1);
   endtask

   task automatic t_default_build();
      do_reset();
      goto(8191);
      check("R1 default no early flag", flag_d, 0);
      goto(8192);
      check("R1 default 8192 cycles", flag_d, 1);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(150000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      t_reset_and_first_tick();
      t_collision();
      t_rate_longer();
      t_rate_longest();
      t_rate_elapsed();
      t_default_build();
      finish_run();
   end

endmodule